// File: doc/BRIEF.md
# PCI Bridge Forwarding Window Decoder

This block decides, for a PCI-to-PCI bridge, whether a transaction seen on the primary side belongs on the secondary side. It takes the bridge's programmed I/O, memory and prefetchable-memory base and limit fields, the I/O and memory space enables, and the legacy VGA enable. From these it rebuilds three address windows as full 64-bit base and limit values. It exposes each window with an active flag.

A request presents an address and a space type (I/O or memory) together with a valid strobe. One clock later the block returns a registered forward decision. The decision is set when any of these matches:

- the I/O window, for an I/O request;
- either memory window, for a memory request;
- one of the legacy VGA ranges, when the VGA enable is set.

The configuration inputs are sampled in the same cycle as the request.

Top module: `bridge_window_decoder`

## Requirements
- R1: The I/O window base has address bits 15:12 equal to I/O base byte bits 7:4. When that byte's bits 3:0 equal 4'h1 (32-bit I/O), its bits 31:16 equal the 16-bit I/O base upper register. Every other base bit is zero.
- R2: The I/O window limit is built the same way from the I/O limit byte and the I/O limit upper register, using the limit byte's own type field. Its bits 11:0 are then all ones.
- R3: The memory window base and limit carry register bits 15:4 at address bits 31:20, and bits 63:32 are zero. The base has bits 19:0 zero and the limit has bits 19:0 all ones.
- R4: The prefetchable window base and limit carry register bits 15:4 at address bits 31:20. When that register's bits 3:0 equal 4'h1 (64-bit), the matching 32-bit upper register supplies bits 63:32; otherwise those bits are zero. The limit has bits 19:0 all ones.
- R5: A window is active only when its space enable is set and its limit is at or above its base, compared unsigned. The I/O enable governs the I/O window; the memory enable governs both memory windows.
- R6: An active window matches an address when base <= address <= limit, compared as unsigned 64-bit values, inclusive at both ends.
- R7: A memory request is forwarded if it matches the memory window or the prefetchable window. An I/O request is judged only against the I/O window and the VGA I/O ranges.
- R8: With the VGA enable set, the following are forwarded:
  - memory requests in 0xA0000..0xBFFFF, when the memory enable is set;
  - I/O requests whose low 16 address bits fall in 0x3B0..0x3BB or 0x3C0..0x3DF, when the I/O enable is set.
  With the VGA enable clear, none of these ranges is forwarded on its own.
- R9: Programming every base address bit to one and every limit address bit to zero leaves the window inactive, so it forwards nothing.
- R10: fwd_valid_o is high exactly in the cycle after a cycle with req_valid_i high. fwd_hit_o is low whenever fwd_valid_o is low.
- R11: While reset is asserted, fwd_valid_o and fwd_hit_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_io_en_i | input | 1 | I/O space enable |
| cmd_mem_en_i | input | 1 | Memory space enable |
| vga_en_i | input | 1 | Legacy VGA forwarding enable |
| io_base_i | input | 8 | I/O base byte (bits 7:4 address, 3:0 type) |
| io_limit_i | input | 8 | I/O limit byte (bits 7:4 address, 3:0 type) |
| io_base_up_i | input | 16 | I/O base address bits 31:16 |
| io_limit_up_i | input | 16 | I/O limit address bits 31:16 |
| mem_base_i | input | 16 | Memory base register |
| mem_limit_i | input | 16 | Memory limit register |
| pf_base_i | input | 16 | Prefetchable base register (bits 3:0 type) |
| pf_limit_i | input | 16 | Prefetchable limit register (bits 3:0 type) |
| pf_base_up_i | input | 32 | Prefetchable base address bits 63:32 |
| pf_limit_up_i | input | 32 | Prefetchable limit address bits 63:32 |
| req_valid_i | input | 1 | Request strobe |
| req_is_io_i | input | 1 | Request space: 1 = I/O, 0 = memory |
| req_addr_i | input | 64 | Request address |
| fwd_valid_o | output | 1 | Decision valid, one cycle after the request |
| fwd_hit_o | output | 1 | Forward to secondary side |
| io_base_o | output | 64 | I/O window base |
| io_limit_o | output | 64 | I/O window limit |
| mem_base_o | output | 64 | Memory window base |
| mem_limit_o | output | 64 | Memory window limit |
| pf_base_o | output | 64 | Prefetchable window base |
| pf_limit_o | output | 64 | Prefetchable window limit |
| io_active_o | output | 1 | I/O window active |
| mem_active_o | output | 1 | Memory window active |
| pf_active_o | output | 1 | Prefetchable window active |

## Verification
The bench probes each window exactly at base, at limit and one step outside either end. A comparator that is off by one, or exclusive at an end, turns one of those edge probes into a wrong decision.

Type fields are exercised with their upper registers holding non-zero junk:
- a decoder that ignores the type field lets the junk into the high address bits and misses addresses it should hit;
- a decoder that never applies the upper register misses above-4 GB and above-64 KB windows.

The disable pattern, inverted limit-below-base windows and cleared space enables must all forward nothing; a design without the empty-window check would claim huge spans instead. The VGA ranges are hit at both edges of every range and with I/O upper address bits set, so a full-width I/O compare or a wrong range edge shows up as a missed or extra forward.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int ADDR_W    = 64;
  localparam int IO_GRAN   = 12;
  localparam int MEM_GRAN  = 20;
  localparam int NUM_WIN   = 3;
  localparam int IO_REG_W  = 8;
  localparam int IO_UP_W   = 16;
  localparam int MEM_REG_W = 16;
  localparam int PF_UP_W   = 32;

  localparam logic [3:0] IO_TYPE_32 = 4'h1;
  localparam logic [3:0] PF_TYPE_64 = 4'h1;

  localparam logic [ADDR_W-1:0] VGA_MEM_LO = 64'h000A_0000;
  localparam logic [ADDR_W-1:0] VGA_MEM_HI = 64'h000B_FFFF;
  localparam logic [15:0] VGA_IO_A_LO = 16'h03B0;
  localparam logic [15:0] VGA_IO_A_HI = 16'h03BB;
  localparam logic [15:0] VGA_IO_B_LO = 16'h03C0;
  localparam logic [15:0] VGA_IO_B_HI = 16'h03DF;

  typedef enum logic [1:0] {WIN_IO = 2'd0, WIN_MEM = 2'd1, WIN_PF = 2'd2} win_kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic              active;
  } win_t;
endpackage

// File: rtl/bwd_window_calc.sv
module bwd_window_calc
  import bwd_pkg::*;
#(
  parameter win_kind_e KIND = WIN_MEM
) (
  input  logic [MEM_REG_W-1:0] base_reg_i,
  input  logic [MEM_REG_W-1:0] limit_reg_i,
  input  logic [PF_UP_W-1:0]   base_up_i,
  input  logic [PF_UP_W-1:0]   limit_up_i,
  input  logic                 en_i,
  output win_t                 win_o
);
  logic [ADDR_W-1:0] base, limit;
  logic              unused_bits;

  if (KIND == WIN_IO) begin : g_io
    logic [IO_UP_W-1:0] b_up, l_up;
    assign b_up  = (base_reg_i[3:0]  == IO_TYPE_32) ? base_up_i[IO_UP_W-1:0]  : '0;
    assign l_up  = (limit_reg_i[3:0] == IO_TYPE_32) ? limit_up_i[IO_UP_W-1:0] : '0;
    assign base  = {32'h0, b_up, base_reg_i[7:4], {IO_GRAN{1'b0}}};
    assign limit = {32'h0, l_up, limit_reg_i[7:4], {IO_GRAN{1'b1}}};
    assign unused_bits = ^{base_reg_i[MEM_REG_W-1:IO_REG_W], limit_reg_i[MEM_REG_W-1:IO_REG_W],
                           base_up_i[PF_UP_W-1:IO_UP_W], limit_up_i[PF_UP_W-1:IO_UP_W]};
  end else if (KIND == WIN_MEM) begin : g_mem
    assign base  = {32'h0, base_reg_i[15:4], {MEM_GRAN{1'b0}}};
    assign limit = {32'h0, limit_reg_i[15:4], {MEM_GRAN{1'b1}}};
    assign unused_bits = ^{base_reg_i[3:0], limit_reg_i[3:0], base_up_i, limit_up_i};
  end else begin : g_pf
    logic [PF_UP_W-1:0] b_up, l_up;
    assign b_up  = (base_reg_i[3:0]  == PF_TYPE_64) ? base_up_i  : '0;
    assign l_up  = (limit_reg_i[3:0] == PF_TYPE_64) ? limit_up_i : '0;
    assign base  = {b_up, base_reg_i[15:4], {MEM_GRAN{1'b0}}};
    assign limit = {l_up, limit_reg_i[15:4], {MEM_GRAN{1'b1}}};
    assign unused_bits = 1'b0;
  end

  assign win_o.base   = base;
  assign win_o.limit  = limit;
  assign win_o.active = en_i && (limit >= base);
endmodule

// File: rtl/bwd_range_hit.sv
module bwd_range_hit
  import bwd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  win_t              win_i,
  output logic              hit_o
);
  assign hit_o = win_i.active && (addr_i >= win_i.base) && (addr_i <= win_i.limit);
endmodule

// File: rtl/bwd_vga_decode.sv
module bwd_vga_decode
  import bwd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              is_io_i,
  input  logic              vga_en_i,
  input  logic              io_en_i,
  input  logic              mem_en_i,
  output logic              hit_o
);
  logic [15:0] io_lo;
  logic        mem_in, io_in;

  // only the low 16 bits take part in legacy I/O decode
  assign io_lo  = addr_i[15:0];
  assign mem_in = (addr_i >= VGA_MEM_LO) && (addr_i <= VGA_MEM_HI);
  assign io_in  = ((io_lo >= VGA_IO_A_LO) && (io_lo <= VGA_IO_A_HI)) ||
                  ((io_lo >= VGA_IO_B_LO) && (io_lo <= VGA_IO_B_HI));
  assign hit_o  = vga_en_i && (is_io_i ? (io_en_i && io_in) : (mem_en_i && mem_in));
endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
  import bwd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_io_en_i,
  input  logic               cmd_mem_en_i,
  input  logic               vga_en_i,
  input  logic [IO_REG_W-1:0]  io_base_i,
  input  logic [IO_REG_W-1:0]  io_limit_i,
  input  logic [IO_UP_W-1:0]   io_base_up_i,
  input  logic [IO_UP_W-1:0]   io_limit_up_i,
  input  logic [MEM_REG_W-1:0] mem_base_i,
  input  logic [MEM_REG_W-1:0] mem_limit_i,
  input  logic [MEM_REG_W-1:0] pf_base_i,
  input  logic [MEM_REG_W-1:0] pf_limit_i,
  input  logic [PF_UP_W-1:0]   pf_base_up_i,
  input  logic [PF_UP_W-1:0]   pf_limit_up_i,
  input  logic               req_valid_i,
  input  logic               req_is_io_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  output logic               fwd_valid_o,
  output logic               fwd_hit_o,
  output logic [ADDR_W-1:0]  io_base_o,
  output logic [ADDR_W-1:0]  io_limit_o,
  output logic [ADDR_W-1:0]  mem_base_o,
  output logic [ADDR_W-1:0]  mem_limit_o,
  output logic [ADDR_W-1:0]  pf_base_o,
  output logic [ADDR_W-1:0]  pf_limit_o,
  output logic               io_active_o,
  output logic               mem_active_o,
  output logic               pf_active_o
);
  logic [MEM_REG_W-1:0] b_reg [NUM_WIN];
  logic [MEM_REG_W-1:0] l_reg [NUM_WIN];
  logic [PF_UP_W-1:0]   b_up  [NUM_WIN];
  logic [PF_UP_W-1:0]   l_up  [NUM_WIN];
  logic                 en    [NUM_WIN];
  win_t                 win   [NUM_WIN];
  logic [NUM_WIN-1:0]   win_hit;
  logic                 vga_hit, hit_d;
  logic                 valid_q, hit_q;

  assign b_reg[WIN_IO]  = {{(MEM_REG_W-IO_REG_W){1'b0}}, io_base_i};
  assign l_reg[WIN_IO]  = {{(MEM_REG_W-IO_REG_W){1'b0}}, io_limit_i};
  assign b_up[WIN_IO]   = {{(PF_UP_W-IO_UP_W){1'b0}}, io_base_up_i};
  assign l_up[WIN_IO]   = {{(PF_UP_W-IO_UP_W){1'b0}}, io_limit_up_i};
  assign en[WIN_IO]     = cmd_io_en_i;
  assign b_reg[WIN_MEM] = mem_base_i;
  assign l_reg[WIN_MEM] = mem_limit_i;
  assign b_up[WIN_MEM]  = '0;
  assign l_up[WIN_MEM]  = '0;
  assign en[WIN_MEM]    = cmd_mem_en_i;
  assign b_reg[WIN_PF]  = pf_base_i;
  assign l_reg[WIN_PF]  = pf_limit_i;
  assign b_up[WIN_PF]   = pf_base_up_i;
  assign l_up[WIN_PF]   = pf_limit_up_i;
  assign en[WIN_PF]     = cmd_mem_en_i;

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    bwd_window_calc #(.KIND(win_kind_e'(k))) u_calc (
      .base_reg_i (b_reg[k]),
      .limit_reg_i(l_reg[k]),
      .base_up_i  (b_up[k]),
      .limit_up_i (l_up[k]),
      .en_i       (en[k]),
      .win_o      (win[k])
    );
    bwd_range_hit u_hit (
      .addr_i(req_addr_i),
      .win_i (win[k]),
      .hit_o (win_hit[k])
    );
  end

  bwd_vga_decode u_vga (
    .addr_i  (req_addr_i),
    .is_io_i (req_is_io_i),
    .vga_en_i(vga_en_i),
    .io_en_i (cmd_io_en_i),
    .mem_en_i(cmd_mem_en_i),
    .hit_o   (vga_hit)
  );

  assign hit_d = vga_hit || (req_is_io_i ? win_hit[WIN_IO]
                                         : (win_hit[WIN_MEM] || win_hit[WIN_PF]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      valid_q <= req_valid_i;
      hit_q   <= req_valid_i && hit_d;
    end
  end

  assign fwd_valid_o  = valid_q;
  assign fwd_hit_o    = hit_q;
  assign io_base_o    = win[WIN_IO].base;
  assign io_limit_o   = win[WIN_IO].limit;
  assign mem_base_o   = win[WIN_MEM].base;
  assign mem_limit_o  = win[WIN_MEM].limit;
  assign pf_base_o    = win[WIN_PF].base;
  assign pf_limit_o   = win[WIN_PF].limit;
  assign io_active_o  = win[WIN_IO].active;
  assign mem_active_o = win[WIN_MEM].active;
  assign pf_active_o  = win[WIN_PF].active;
endmodule

// File: rtl/bwd_chk.sv
module bwd_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_io_en_i,
  input logic        cmd_mem_en_i,
  input logic        req_valid_i,
  input logic        req_is_io_i,
  input logic        fwd_valid_o,
  input logic        fwd_hit_o,
  input logic [63:0] io_base_o,
  input logic [63:0] io_limit_o,
  input logic [63:0] mem_base_o,
  input logic [63:0] mem_limit_o,
  input logic        io_active_o,
  input logic        mem_active_o,
  input logic        pf_active_o
);
  // R10
  valid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> fwd_valid_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!fwd_valid_o && !fwd_hit_o));
  // R5
  io_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_active_o |-> cmd_io_en_i);
  // R5
  mem_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_active_o || pf_active_o) |-> cmd_mem_en_i);
  // R7
  mem_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_is_io_i && !cmd_mem_en_i) |=> !fwd_hit_o);
  // R7
  io_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_is_io_i && !cmd_io_en_i) |=> !fwd_hit_o);
  // R2
  io_gran_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_limit_o[11:0] == 12'hFFF) && (io_base_o[11:0] == 12'h000));
  // R3
  mem_gran_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_limit_o[19:0] == 20'hFFFFF) && (mem_base_o[19:0] == 20'h0) &&
    (mem_base_o[63:32] == 32'h0) && (mem_limit_o[63:32] == 32'h0));
endmodule

bind bridge_window_decoder bwd_chk u_chk (.*);

// File: tb/bridge_window_decoder_test.sv
module bridge_window_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        io_en = 0, mem_en = 0, vga_en = 0;
  logic [7:0]  iob = 0, iol = 0;
  logic [15:0] iobu = 0, iolu = 0;
  logic [15:0] mb = 0, ml = 0, pb = 0, pl = 0;
  logic [31:0] pbu = 0, plu = 0;
  logic        rv = 0, rio = 0;
  logic [63:0] ra = 0;
  logic        fv, fh, ioa, mema, pfa;
  logic [63:0] iobo, iolo, mbo, mlo, pbo, plo;

  int compared = 0, mismatched = 0;
  bit done = 0;
  bit     exp_q[$];
  string  tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_window_decoder uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_io_en_i(io_en), .cmd_mem_en_i(mem_en), .vga_en_i(vga_en),
    .io_base_i(iob), .io_limit_i(iol), .io_base_up_i(iobu), .io_limit_up_i(iolu),
    .mem_base_i(mb), .mem_limit_i(ml), .pf_base_i(pb), .pf_limit_i(pl),
    .pf_base_up_i(pbu), .pf_limit_up_i(plu),
    .req_valid_i(rv), .req_is_io_i(rio), .req_addr_i(ra),
    .fwd_valid_o(fv), .fwd_hit_o(fh),
    .io_base_o(iobo), .io_limit_o(iolo), .mem_base_o(mbo), .mem_limit_o(mlo),
    .pf_base_o(pbo), .pf_limit_o(plo),
    .io_active_o(ioa), .mem_active_o(mema), .pf_active_o(pfa)
  );

  function automatic logic [63:0] m_io(input logic [7:0] r, input logic [15:0] up, input bit lim);
    logic [63:0] v = '0;
    v[15:12] = r[7:4];
    if (r[3:0] == 4'h1) v[31:16] = up;
    if (lim) v[11:0] = 12'hFFF;
    return v;
  endfunction

  function automatic logic [63:0] m_mem(input logic [15:0] r, input logic [31:0] up,
                                        input bit pf, input bit lim);
    logic [63:0] v = '0;
    v[31:20] = r[15:4];
    if (pf && r[3:0] == 4'h1) v[63:32] = up;
    if (lim) v[19:0] = 20'hFFFFF;
    return v;
  endfunction

  function automatic bit m_hit(input bit is_io, input logic [63:0] a);
    logic [63:0] ib = m_io(iob, iobu, 0), il = m_io(iol, iolu, 1);
    logic [63:0] mbv = m_mem(mb, 0, 0, 0), mlv = m_mem(ml, 0, 0, 1);
    logic [63:0] pbv = m_mem(pb, pbu, 1, 0), plv = m_mem(pl, plu, 1, 1);
    bit io_w  = io_en && il >= ib && a >= ib && a <= il;
    bit mem_w = mem_en && mlv >= mbv && a >= mbv && a <= mlv;
    bit pf_w  = mem_en && plv >= pbv && a >= pbv && a <= plv;
    bit vio   = vga_en && io_en && ((a[15:0] >= 16'h3B0 && a[15:0] <= 16'h3BB) ||
                                    (a[15:0] >= 16'h3C0 && a[15:0] <= 16'h3DF));
    bit vmem  = vga_en && mem_en && a >= 64'hA0000 && a <= 64'hBFFFF;
    return is_io ? (io_w || vio) : (mem_w || pf_w || vmem);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_windows();
    #1;
    chk("R1 io base", iobo, m_io(iob, iobu, 0));
    chk("R2 io limit", iolo, m_io(iol, iolu, 1));
    chk("R3 mem base", mbo, m_mem(mb, 0, 0, 0));
    chk("R3 mem limit", mlo, m_mem(ml, 0, 0, 1));
    chk("R4 pf base", pbo, m_mem(pb, pbu, 1, 0));
    chk("R4 pf limit", plo, m_mem(pl, plu, 1, 1));
    chk("R5 io active", ioa, io_en && m_io(iol, iolu, 1) >= m_io(iob, iobu, 0));
    chk("R5 mem active", mema, mem_en && m_mem(ml, 0, 0, 1) >= m_mem(mb, 0, 0, 0));
    chk("R5 pf active", pfa, mem_en && m_mem(pl, plu, 1, 1) >= m_mem(pb, pbu, 1, 0));
  endtask

  // driver: one request per cycle, expected result queued
  task automatic send(input bit is_io, input logic [63:0] a, input string tag);
    @(negedge clk);
    rv = 1; rio = is_io; ra = a;
    exp_q.push_back(m_hit(is_io, a));
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    rv = 0;
    @(posedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && fv) begin
      if (exp_q.size() == 0) chk("R10 unexpected response", 1, 0);
      else begin
        automatic bit    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, fh, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset valid", fv, 0);
    chk("R11 reset hit", fh, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk);

    // I/O 16-bit window 0x2000..0x3FFF, upper junk ignored
    io_en = 1; iob = 8'h20; iol = 8'h30; iobu = 16'h0005; iolu = 16'h0007;
    pb = 16'hFFF0; pl = 16'h0000; pbu = 32'hFFFF_FFFF; plu = 0;
    chk_windows();
    send(1, 64'h2000, "R6 io at base");
    send(1, 64'h1FFF, "R6 io below base");
    send(1, 64'h3FFF, "R6 io at limit");
    send(1, 64'h4000, "R6 io above limit");
    send(1, 64'h5_2000, "R1 io upper junk ignored");
    // I/O 32-bit window 0x12000..0x12FFF
    iob = 8'h21; iol = 8'h21; iobu = 16'h0001; iolu = 16'h0001;
    chk_windows();
    send(1, 64'h12000, "R1 io32 base");
    send(1, 64'h12FFF, "R2 io32 limit");
    send(1, 64'h2000, "R1 io32 upper required");
    // memory window 0x1000_0000..0x101F_FFFF
    mem_en = 1; mb = 16'h1000; ml = 16'h1010;
    chk_windows();
    send(0, 64'h1000_0000, "R6 mem at base");
    send(0, 64'h0FFF_FFFF, "R6 mem below base");
    send(0, 64'h101F_FFFF, "R6 mem at limit");
    send(0, 64'h1020_0000, "R6 mem above limit");
    send(1, 64'h1000_0000, "R7 io request not in mem window");
    send(0, 64'h12000, "R7 mem request not in io window");
    // prefetchable 64-bit 0x1_8000_0000..0x1_801F_FFFF
    pb = 16'h8001; pl = 16'h8011; pbu = 32'h1; plu = 32'h1;
    chk_windows();
    send(0, 64'h1_8000_0000, "R4 pf64 base");
    send(0, 64'h1_801F_FFFF, "R4 pf64 limit");
    send(0, 64'h1_8020_0000, "R6 pf64 above");
    send(0, 64'h8000_0000, "R4 pf64 upper required");
    send(0, 64'h1000_0000, "R7 mem window still hits");
    // prefetchable 32-bit, upper junk ignored
    pb = 16'h8000; pl = 16'h8010; pbu = 32'h5; plu = 32'h5;
    chk_windows();
    send(0, 64'h8000_0000, "R4 pf32 base");
    send(0, 64'h5_8000_0000, "R4 pf32 upper ignored");
    // enables off
    mem_en = 0; io_en = 0;
    chk_windows();
    send(0, 64'h1000_0000, "R5 mem disabled");
    send(1, 64'h12000, "R5 io disabled");
    // disable pattern
    mem_en = 1; io_en = 1;
    iob = 8'hF1; iol = 8'h01; iobu = 16'hFFFF; iolu = 16'h0000;
    mb = 16'hFFF0; ml = 16'h0000; pb = 16'hFFF1; pl = 16'h0001; pbu = '1; plu = '0;
    chk_windows();
    send(0, 64'h0, "R9 mem zero");
    send(0, 64'h000F_FFFF, "R9 mem low");
    send(1, 64'h0FFF, "R9 io low");
    // inverted memory window
    mb = 16'h2000; ml = 16'h1000;
    chk_windows();
    send(0, 64'h1800_0000, "R5 inverted window");
    // VGA
    vga_en = 1;
    send(0, 64'hA0000, "R8 vga mem low");
    send(0, 64'hBFFFF, "R8 vga mem high");
    send(0, 64'h9FFFF, "R8 vga mem below");
    send(0, 64'hC0000, "R8 vga mem above");
    send(1, 64'h3B0, "R8 vga io a low");
    send(1, 64'h3BB, "R8 vga io a high");
    send(1, 64'h3BC, "R8 vga io gap");
    send(1, 64'h3C0, "R8 vga io b low");
    send(1, 64'h3DF, "R8 vga io b high");
    send(1, 64'h3E0, "R8 vga io above");
    send(1, 64'h1_03C0, "R8 vga io upper bits ignored");
    send(1, 64'hA0000, "R8 vga mem range not io");
    io_en = 0;
    send(1, 64'h3C0, "R8 vga io gated by enable");
    vga_en = 0; io_en = 1;
    send(0, 64'hA0000, "R8 vga off mem");
    send(1, 64'h3C0, "R8 vga off io");
    idle();
    @(negedge clk);
    chk("R10 idle valid", fv, 0);
    chk("R10 idle hit", fh, 0);
    repeat (2) @(negedge clk);
    chk("R10 all responses seen", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule